// File: doc/BRIEF.md
# Cache Flush Sequencer

This block handles a whole-cache flush for a 2-way set-associative cache of 512 sets with 64-byte lines. When a flush is requested it walks every line of the tag store. Each line that holds modified data has its modified flag cleared. The line is then either copied back to memory as a burst of 32-bit words or dropped, depending on the mode chosen when the flush starts.

Once every line has been visited, the sequencer sends one broadcast strobe to the cache arrays. That strobe clears all valid flags, all modified flags and the per-set replacement pointers. After it, a single-cycle completion pulse is raised.

The surrounding cache owns the arrays. The sequencer gives it a line pointer and read strobes, and the arrays answer one cycle after each read. The sequencer also drives a word-wide memory write channel with a valid/ready handshake.

Top module: `flush_sweeper`

## Requirements
- R1: Lines are visited set-major: set 0 up to set 511, and within each set way 0 before way 1. Both modified-flag clears and write-back bursts appear in that order.
- R2: Every line reported as modified when probed has its modified flag cleared while it is visited, in both modes. No modified line remains once the flush ends.
- R3: In write-back mode, a modified line produces 16 word writes in rising word order. Word k goes to address {tag, set, k, 2'b00}, and its data is the array word read with that set, way and word index. Array responses arrive one cycle after the read strobe.
- R4: In discard mode, no memory write is ever offered.
- R5: After the last line is visited, `wipe_o` is high for exactly one cycle. It comes after all clears and memory writes of the flush.
- R6: `done_o` is high for exactly one cycle, on the cycle right after `wipe_o`. `busy_o` stays high from the accepted start until that cycle and is low afterwards.
- R7: A start request while a flush is in progress is ignored. It neither restarts the walk nor changes the mode, and it gives no second completion.
- R8: While `mw_valid_o` is high and `mw_ready_i` is low, the offered address and data stay unchanged. The sequencer never drops or repeats a word.
- R9: During and right after reset, `busy_o`, `done_o`, `wipe_o`, `mw_valid_o` and `meta_rd_o` are low.
- R10: Lines that are not modified cause no flag clear and no memory traffic. A flush of a fully clean cache still produces the wipe strobe and the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Flush request, sampled only when idle |
| wb_mode_i | input | 1 | 1 = write back modified lines, 0 = discard them |
| busy_o | output | 1 | Flush in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cur_set_o | output | 9 | Set index of the line being visited |
| cur_way_o | output | 1 | Way index of the line being visited |
| cur_word_o | output | 4 | Word index for line data reads |
| meta_rd_o | output | 1 | Tag/flag read strobe for the current line |
| meta_dirty_i | input | 1 | Modified flag, one cycle after `meta_rd_o` |
| meta_tag_i | input | 17 | Stored tag, one cycle after `meta_rd_o` |
| meta_clr_o | output | 1 | Clear the modified flag of the current line |
| line_rd_o | output | 1 | Line data read strobe |
| line_data_i | input | 32 | Line word, one cycle after `line_rd_o` |
| mw_valid_o | output | 1 | Memory write offered |
| mw_ready_i | input | 1 | Memory accepts the write |
| mw_addr_o | output | 32 | Byte address of the write |
| mw_data_o | output | 32 | Write data |
| wipe_o | output | 1 | Reset all valid, modified and replacement state |

## Verification
Some rules are checked on every clock cycle. These are the stability of an offered write under back-pressure and the exclusion of writes in discard mode. Also checked each cycle: a flag clear only follows a modified response, completion follows the wipe strobe directly, and busy never drops before completion. The remaining behaviour can only be seen by comparing a whole flush with a cache image the bench seeded itself. That covers the set-major order, the exact address and data of each burst, that no modified flag is left over, and that an overlapping start is ignored.

// File: rtl/flush_pkg.sv
package flush_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROBE,
    S_CHECK,
    S_FETCH,
    S_LOAD,
    S_SEND,
    S_WIPE,
    S_FIN
  } sweep_state_e;

endpackage

// File: rtl/flush_rst_sync.sv
module flush_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;

endmodule

// File: rtl/flush_scan_ptr.sv
module flush_scan_ptr #(
  parameter int SET_W = 9,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [SET_W-1:0] set_o,
  output logic [WAY_W-1:0] way_o,
  output logic             last_o
);

  localparam int IDX_W = SET_W + WAY_W;

  // Way bits sit below set bits, so a plain increment walks set-major.
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = clr | step;
    idx_d  = clr ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign set_o  = idx_q[IDX_W-1:WAY_W];
  assign way_o  = idx_q[WAY_W-1:0];
  assign last_o = &idx_q;

endmodule

// File: rtl/flush_beat_ctr.sv
module flush_beat_ctr #(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);

  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_d;
  logic              beat_en;

  always_comb begin
    beat_en = clr | step;
    beat_d  = clr ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  assign beat_o = beat_q;
  assign last_o = &beat_q;

endmodule

// File: rtl/flush_addr_gen.sv
module flush_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 9,
  parameter int LINE_W = 6,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-SET_W-LINE_W-1:0]        tag_i,
  input  logic [SET_W-1:0]                      set_i,
  input  logic [LINE_W-$clog2(DATA_W/8)-1:0]    beat_i,
  output logic [ADDR_W-1:0]                     addr_o
);

  localparam int BYTE_W = $clog2(DATA_W / 8);

  always_comb begin
    addr_o = {tag_i, set_i, beat_i, {BYTE_W{1'b0}}};
  end

endmodule

// File: rtl/flush_sweeper.sv
module flush_sweeper #(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 9,
  parameter int WAY_W  = 1,
  parameter int LINE_W = 6,
  parameter int DATA_W = 32,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int BEAT_W = LINE_W - BYTE_W,
  localparam int TAG_W  = ADDR_W - SET_W - LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wb_mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SET_W-1:0]  cur_set_o,
  output logic [WAY_W-1:0]  cur_way_o,
  output logic [BEAT_W-1:0] cur_word_o,
  output logic              meta_rd_o,
  input  logic              meta_dirty_i,
  input  logic [TAG_W-1:0]  meta_tag_i,
  output logic              meta_clr_o,
  output logic              line_rd_o,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              mw_valid_o,
  input  logic              mw_ready_i,
  output logic [ADDR_W-1:0] mw_addr_o,
  output logic [DATA_W-1:0] mw_data_o,
  output logic              wipe_o
);

  import flush_pkg::*;

  logic srst_n;

  sweep_state_e st_q, st_d;
  logic              mode_q;
  logic              mode_en;
  logic [TAG_W-1:0]  tag_q;
  logic              tag_en;
  logic [DATA_W-1:0] wdata_q;
  logic              load_en;

  logic scan_clr, scan_step, scan_last;
  logic beat_clr, beat_step, beat_last;

  flush_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  flush_scan_ptr #(
    .SET_W (SET_W),
    .WAY_W (WAY_W)
  ) u_scan (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr    (scan_clr),
    .step   (scan_step),
    .set_o  (cur_set_o),
    .way_o  (cur_way_o),
    .last_o (scan_last)
  );

  flush_beat_ctr #(
    .BEAT_W (BEAT_W)
  ) u_beat (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr    (beat_clr),
    .step   (beat_step),
    .beat_o (cur_word_o),
    .last_o (beat_last)
  );

  flush_addr_gen #(
    .ADDR_W (ADDR_W),
    .SET_W  (SET_W),
    .LINE_W (LINE_W),
    .DATA_W (DATA_W)
  ) u_addr (
    .tag_i  (tag_q),
    .set_i  (cur_set_o),
    .beat_i (cur_word_o),
    .addr_o (mw_addr_o)
  );

  // Next-state and output decode
  always_comb begin
    st_d       = st_q;
    mode_en    = 1'b0;
    tag_en     = 1'b0;
    load_en    = 1'b0;
    scan_clr   = 1'b0;
    scan_step  = 1'b0;
    beat_clr   = 1'b0;
    beat_step  = 1'b0;
    meta_rd_o  = 1'b0;
    meta_clr_o = 1'b0;
    line_rd_o  = 1'b0;
    mw_valid_o = 1'b0;
    wipe_o     = 1'b0;
    done_o     = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          mode_en  = 1'b1;
          scan_clr = 1'b1;
          st_d     = S_PROBE;
        end
      end
      S_PROBE: begin
        meta_rd_o = 1'b1;
        st_d      = S_CHECK;
      end
      S_CHECK: begin
        if (meta_dirty_i) begin
          meta_clr_o = 1'b1;
          tag_en     = 1'b1;
        end
        if (meta_dirty_i && mode_q) begin
          beat_clr = 1'b1;
          st_d     = S_FETCH;
        end else if (scan_last) begin
          st_d = S_WIPE;
        end else begin
          scan_step = 1'b1;
          st_d      = S_PROBE;
        end
      end
      S_FETCH: begin
        line_rd_o = 1'b1;
        st_d      = S_LOAD;
      end
      S_LOAD: begin
        load_en = 1'b1;
        st_d    = S_SEND;
      end
      S_SEND: begin
        mw_valid_o = 1'b1;
        if (mw_ready_i) begin
          if (!beat_last) begin
            beat_step = 1'b1;
            st_d      = S_FETCH;
          end else if (scan_last) begin
            st_d = S_WIPE;
          end else begin
            scan_step = 1'b1;
            st_d      = S_PROBE;
          end
        end
      end
      S_WIPE: begin
        wipe_o = 1'b1;
        st_d   = S_FIN;
      end
      S_FIN: begin
        done_o = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // State and datapath registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= 1'b0;
    end else if (mode_en) begin
      mode_q <= wb_mode_i;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= meta_tag_i;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wdata_q <= '0;
    end else if (load_en) begin
      wdata_q <= line_data_i;
    end
  end

  assign busy_o    = (st_q != S_IDLE);
  assign mw_data_o = wdata_q;

endmodule

// File: rtl/flush_sweeper_chk.sv
module flush_sweeper_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              wipe_o,
  input logic              meta_rd_o,
  input logic              meta_clr_o,
  input logic              meta_dirty_i,
  input logic              line_rd_o,
  input logic              mw_valid_o,
  input logic              mw_ready_i,
  input logic [ADDR_W-1:0] mw_addr_o,
  input logic [DATA_W-1:0] mw_data_o,
  input logic              mode_q
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid_o && !mw_ready_i) |=> (mw_valid_o && $stable(mw_addr_o) && $stable(mw_data_o)));

  p_discard_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid_o |-> mode_q);

  p_clear_only_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    meta_clr_o |-> meta_dirty_i);

  p_wipe_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_o |=> done_o);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  p_fetch_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_valid_o) |-> $past(line_rd_o, 2));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mw_valid_o && !meta_rd_o && !wipe_o));

endmodule

bind flush_sweeper flush_sweeper_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .wipe_o       (wipe_o),
  .meta_rd_o    (meta_rd_o),
  .meta_clr_o   (meta_clr_o),
  .meta_dirty_i (meta_dirty_i),
  .line_rd_o    (line_rd_o),
  .mw_valid_o   (mw_valid_o),
  .mw_ready_i   (mw_ready_i),
  .mw_addr_o    (mw_addr_o),
  .mw_data_o    (mw_data_o),
  .mode_q       (mode_q)
);

// File: tb/tb_flush_sweeper.sv
module tb_flush_sweeper;

  localparam int NLINES = 1024;
  localparam int LOGN   = 512;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        wb_mode_i;
  logic        busy_o;
  logic        done_o;
  logic [8:0]  cur_set_o;
  logic [0:0]  cur_way_o;
  logic [3:0]  cur_word_o;
  logic        meta_rd_o;
  logic        meta_dirty_i;
  logic [16:0] meta_tag_i;
  logic        meta_clr_o;
  logic        line_rd_o;
  logic [31:0] line_data_i;
  logic        mw_valid_o;
  logic        mw_ready_i;
  logic [31:0] mw_addr_o;
  logic [31:0] mw_data_o;
  logic        wipe_o;

  flush_sweeper dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wb_mode_i(wb_mode_i),
    .busy_o(busy_o), .done_o(done_o), .cur_set_o(cur_set_o), .cur_way_o(cur_way_o),
    .cur_word_o(cur_word_o), .meta_rd_o(meta_rd_o), .meta_dirty_i(meta_dirty_i),
    .meta_tag_i(meta_tag_i), .meta_clr_o(meta_clr_o), .line_rd_o(line_rd_o),
    .line_data_i(line_data_i), .mw_valid_o(mw_valid_o), .mw_ready_i(mw_ready_i),
    .mw_addr_o(mw_addr_o), .mw_data_o(mw_data_o), .wipe_o(wipe_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk;
  int n_bad;
  bit finished;

  // Cache image model
  logic        dirty_m [NLINES];
  logic [16:0] tag_m   [NLINES];

  // Activity logs
  logic [31:0] log_addr [LOGN];
  logic [31:0] log_data [LOGN];
  int          clr_idx  [LOGN];
  int beat_n, clr_n, clr_bad, hold_bad, wipe_n, done_n;
  int wipe_cyc, done_cyc, last_act_cyc, cyc;
  int rmode, rcnt;
  bit          stall_prev;
  logic [31:0] a_prev, d_prev;

  function automatic logic [31:0] pat(input int s, input int w, input int k);
    logic [8:0] s9;
    logic [3:0] k4;
    s9 = s[8:0];
    k4 = k[3:0];
    return {7'h5A, s9, w[0], k4, 11'h3C1};
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (meta_rd_o) begin
      meta_dirty_i <= dirty_m[{cur_set_o, cur_way_o}];
      meta_tag_i   <= tag_m[{cur_set_o, cur_way_o}];
      last_act_cyc = cyc;
    end
    if (meta_clr_o) begin
      if (!dirty_m[{cur_set_o, cur_way_o}]) clr_bad = clr_bad + 1;
      dirty_m[{cur_set_o, cur_way_o}] = 1'b0;
      if (clr_n < LOGN) clr_idx[clr_n] = int'({cur_set_o, cur_way_o});
      clr_n = clr_n + 1;
      last_act_cyc = cyc;
    end
    if (line_rd_o) line_data_i <= pat(int'(cur_set_o), int'(cur_way_o), int'(cur_word_o));
    if (stall_prev && (!mw_valid_o || mw_addr_o != a_prev || mw_data_o != d_prev))
      hold_bad = hold_bad + 1;
    stall_prev = mw_valid_o && !mw_ready_i;
    a_prev = mw_addr_o;
    d_prev = mw_data_o;
    if (mw_valid_o && mw_ready_i) begin
      if (beat_n < LOGN) begin
        log_addr[beat_n] = mw_addr_o;
        log_data[beat_n] = mw_data_o;
      end
      beat_n = beat_n + 1;
      last_act_cyc = cyc;
    end
    if (wipe_o) begin wipe_n = wipe_n + 1; wipe_cyc = cyc; end
    if (done_o) begin done_n = done_n + 1; done_cyc = cyc; end
    if (cyc > 150000 && !finished) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  // Ready pattern driven away from the active edge
  always @(negedge clk) begin
    rcnt = rcnt + 1;
    if (rmode == 0) mw_ready_i = 1'b1;
    else mw_ready_i = ((rcnt % 5) == 0) || ((rcnt % 5) == 3);
  end

  function automatic void finish_run();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_image();
    for (int i = 0; i < NLINES; i++) begin
      dirty_m[i] = 1'b0;
      tag_m[i]   = 17'(i * 37 + 5);
    end
  endtask

  task automatic mark(input int s, input int w, input int t);
    dirty_m[s * 2 + w] = 1'b1;
    tag_m[s * 2 + w]   = 17'(t);
  endtask

  // Runs one flush and checks it against the seeded image.
  task automatic run_sweep(input bit mode, input int rm, input bit poke);
    int exp_idx [32];
    logic [16:0] exp_tag [32];
    int nd;
    int wait_n;
    int bad_a, bad_d, bad_o;
    bit left;
    nd = 0;
    for (int s = 0; s < 512; s++)
      for (int w = 0; w < 2; w++)
        if (dirty_m[s * 2 + w] && nd < 32) begin
          exp_idx[nd] = s * 2 + w;
          exp_tag[nd] = tag_m[s * 2 + w];
          nd = nd + 1;
        end
    beat_n = 0; clr_n = 0; clr_bad = 0; hold_bad = 0; wipe_n = 0; done_n = 0;
    wipe_cyc = 0; done_cyc = 0; last_act_cyc = 0; rmode = rm;
    @(negedge clk);
    start_i = 1'b1; wb_mode_i = mode;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R6", "busy after start", busy_o, 1);
    wait_n = 0;
    while (done_n == 0 && wait_n < 40000) begin
      @(negedge clk);
      wait_n = wait_n + 1;
      if (poke && wait_n == 60) begin
        start_i = 1'b1; wb_mode_i = ~mode;
      end
      if (poke && wait_n == 61) start_i = 1'b0;
    end
    chk(done_n == 1, "R6", "completion seen", done_n, 1);
    repeat (30) @(negedge clk);
    // R7: no second completion, walk not restarted
    chk(done_n == 1 && wipe_n == 1, "R7", "single completion", done_n, 1);
    chk(busy_o == 1'b0, "R6", "busy after done", busy_o, 0);
    chk(done_cyc == wipe_cyc + 1, "R6", "done cycle after wipe", done_cyc, wipe_cyc + 1);
    chk(wipe_cyc > last_act_cyc, "R5", "wipe after last activity", wipe_cyc, last_act_cyc + 1);
    chk(clr_n == nd, "R2", "clear count", clr_n, nd);
    chk(clr_bad == 0, "R10", "clear of clean line", clr_bad, 0);
    bad_o = 0;
    for (int i = 0; i < nd && i < clr_n; i++)
      if (clr_idx[i] != exp_idx[i]) bad_o = bad_o + 1;
    chk(bad_o == 0, "R1", "clear order mismatches", bad_o, 0);
    left = 1'b0;
    for (int i = 0; i < NLINES; i++) if (dirty_m[i]) left = 1'b1;
    chk(!left, "R2", "modified line left", left, 0);
    if (mode) begin
      chk(beat_n == nd * 16, "R3", "write count", beat_n, nd * 16);
      bad_a = 0; bad_d = 0;
      for (int i = 0; i < nd && i * 16 + 15 < beat_n; i++)
        for (int k = 0; k < 16; k++) begin
          if (log_addr[i * 16 + k] != {exp_tag[i], 9'(exp_idx[i] / 2), 4'(k), 2'b00})
            bad_a = bad_a + 1;
          if (log_data[i * 16 + k] != pat(exp_idx[i] / 2, exp_idx[i] % 2, k))
            bad_d = bad_d + 1;
        end
      chk(bad_a == 0, "R1", "burst address/order mismatches", bad_a, 0);
      chk(bad_d == 0, "R3", "burst data mismatches", bad_d, 0);
      chk(hold_bad == 0, "R8", "offer changed under stall", hold_bad, 0);
    end else begin
      chk(beat_n == 0, "R4", "writes in discard mode", beat_n, 0);
    end
  endtask

  task automatic t_reset_r9();
    rst_n = 1'b0; start_i = 1'b0; wb_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !wipe_o && !mw_valid_o && !meta_rd_o, "R9", "outputs in reset",
        {busy_o, done_o, wipe_o, mw_valid_o, meta_rd_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !wipe_o && !mw_valid_o, "R9", "outputs after reset",
        {busy_o, done_o, wipe_o, mw_valid_o}, 0);
  endtask

  task automatic t_writeback_r3();
    clear_image();
    mark(0, 0, 17'h1ABCD);
    mark(3, 1, 17'h00042);
    mark(7, 0, 17'h0F0F0);
    mark(7, 1, 17'h10001);
    mark(511, 1, 17'h1FFFF);
    run_sweep(1'b1, 0, 1'b0);
  endtask

  task automatic t_backpressure_r8();
    clear_image();
    mark(1, 1, 17'h0AAAA);
    mark(200, 0, 17'h15555);
    mark(511, 0, 17'h00003);
    run_sweep(1'b1, 1, 1'b0);
  endtask

  task automatic t_discard_r4();
    clear_image();
    mark(0, 1, 17'h00011);
    mark(100, 0, 17'h00022);
    mark(100, 1, 17'h00033);
    mark(511, 1, 17'h00044);
    run_sweep(1'b0, 0, 1'b0);
  endtask

  task automatic t_restart_ignored_r7();
    clear_image();
    mark(2, 0, 17'h01234);
    mark(400, 1, 17'h04321);
    run_sweep(1'b1, 0, 1'b1);
  endtask

  task automatic t_all_clean_r10();
    clear_image();
    run_sweep(1'b1, 1, 1'b0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0; cyc = 0; rcnt = 0; rmode = 0;
    stall_prev = 1'b0; a_prev = '0; d_prev = '0;
    beat_n = 0; clr_n = 0; clr_bad = 0; hold_bad = 0; wipe_n = 0; done_n = 0;
    meta_dirty_i = 1'b0; meta_tag_i = '0; line_data_i = '0; mw_ready_i = 1'b1;
    clear_image();
    t_reset_r9();
    t_writeback_r3();
    t_backpressure_r8();
    t_discard_r4();
    t_restart_ignored_r7();
    t_all_clean_r10();
    finish_run();
  end

endmodule